// File: doc/BRIEF.md
# Dual-Protocol Serial Register Slave

This block is the serial front end of a register bank of 8-bit entries. A host reaches the bank through one of two protocols that share the same three signal pins: a two-wire bus with an open-drain data line (I2C-style) or a four-wire SPI link. After reset the block answers as a two-wire slave. The first high-to-low edge seen on the chip-select pin moves it into SPI mode for good; only a new reset brings the two-wire slave back.

In two-wire mode the 7-bit device address is 0x16 plus the value of the two strap pins, read as {strap1, strap0}. A write frame carries a register index and then any number of data bytes. A read frame first sets the index with a short write frame, then uses a repeated START with the read bit set. In SPI mode each frame starts with a direction bit and an 8-bit register index, followed by data bytes. Both protocols walk the index upward through a burst. In SPI mode the strap0 pin serves as the serial output, with its own enable.

All pins pass through two-flop synchronisers, so the system clock must run at least eight times the serial clock. The bank side has no back-pressure. The bank must accept every write strobe. It must also present read data combinationally for `reg_addr_o` in the cycle that `reg_rd_o` is high.

Top module: `dual_serial_regslave`

## Requirements
- R1: After reset the block answers two-wire traffic. The first falling edge on `cs_n_i` selects SPI mode. SPI mode holds until `rst_n` is asserted again, and the two-wire slave works again after that reset.
- R2: The two-wire slave acknowledges (pulls data low in the ninth clock) an address byte whose upper seven bits equal 0x16 + {strap1_i, strap0_i}. The lowest bit of that byte is R/W, with 0 meaning write.
- R3: An address byte that does not match is not acknowledged, and the bytes after it cause no register access until the next START.
- R4: In a two-wire write, the byte after the address loads the register index N. Each following data byte is acknowledged and written to N, N+1, ... in turn.
- R5: In a two-wire read, a repeated START with R/W=1 returns bytes from N, N+1, ..., MSB first. A master ACK asks for the next byte, and a master NACK ends the burst with the data line released.
- R6: In an SPI write, a leading 0 bit is followed by an 8-bit index N, MSB first. The data bytes that follow are written to N, N+1, ... while `cs_n_i` stays low.
- R7: In an SPI read, a leading 1 bit is followed by index N, and bytes from N, N+1, ... are shifted out MSB first. The output changes after falling clock edges and is valid at rising edges. Clock idle-low (mode 0) and idle-high (mode 3) both work.
- R8: `so_oe_o` is low while `cs_n_i` is high and during the nine header bits of every SPI frame.
- R9: The register index wraps from 0xFF to 0x00 within a burst, in both protocols.
- R10: `reg_wr_o` and `reg_rd_o` are single-cycle strobes that are never high together. `ser_dat_oe_o` only pulls low, changes only while the serial clock is low, and is released outside ACK and read-data bits and after STOP.
- R11: In SPI mode, two-wire traffic is ignored. No acknowledge is driven and no register is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Shared serial clock pin (two-wire SCL or SPI SCK) |
| ser_dat_i | input | 1 | Shared data-in pin (two-wire SDA as seen on the wire, or SPI serial input) |
| ser_dat_oe_o | output | 1 | Pull-low enable for the two-wire data line |
| cs_n_i | input | 1 | Active-low chip select; its first falling edge selects SPI mode |
| strap0_i | input | 1 | Address strap bit 0 (two-wire mode) |
| strap1_i | input | 1 | Address strap bit 1 (two-wire mode) |
| so_o | output | 1 | SPI serial output value (driven onto the strap0 pin) |
| so_oe_o | output | 1 | SPI serial output enable; low means high impedance |
| reg_addr_o | output | 8 | Register index presented to the bank |
| reg_wdata_o | output | 8 | Write data for the bank |
| reg_wr_o | output | 1 | One-cycle write strobe |
| reg_rd_o | output | 1 | One-cycle read strobe |
| reg_rdata_i | input | 8 | Bank read data for `reg_addr_o`, valid combinationally |

## Verification
The assertions assume the host follows each protocol's timing as the synchronised block sees it. Two-wire data changes only while the clock is low, except for START and STOP. Serial edges are at least four system clocks apart. Mode is never switched in the middle of a two-wire frame. The stimulus holds every serial level for eight system clocks and moves data two clocks after a clock fall. It switches to SPI only between frames, and it samples every output halfway between serial edges.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [6:0] DEV_BASE = 7'h16;

  typedef enum logic [3:0] {
    TW_IDLE, TW_DEVADR, TW_DEVACK, TW_REGADR, TW_REGACK,
    TW_WRBYTE, TW_WRACK, TW_RDBYTE, TW_RDACK
  } tw_state_e;
endpackage

// File: rtl/dsr_sync.sv
module dsr_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] INIT = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta      <= INIT[i];
        q[i]      <= INIT[i];
        q_prev[i] <= INIT[i];
      end else begin
        meta      <= d[i];
        q[i]      <= meta;
        q_prev[i] <= q[i];
      end
    end
  end
endmodule

// File: rtl/dsr_mode_latch.sv
module dsr_mode_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic cs_n_prev,
  output logic spi_mode
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 spi_mode <= 1'b0;
    else if (cs_n_prev && !cs_n) spi_mode <= 1'b1;
  end
endmodule

// File: rtl/dsr_tw_engine.sv
module dsr_tw_engine import dsr_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              scl,
  input  logic              scl_prev,
  input  logic              sda,
  input  logic              sda_prev,
  input  logic [6:0]        dev_addr,
  output logic              sda_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_wr,
  output logic              reg_rd,
  input  logic [BYTE_W-1:0] reg_rdata
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ALL_BITS = CNT_W'(BYTE_W);

  tw_state_e         st;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh, txb, txs, byte_in;
  logic [ADDR_W-1:0] ptr;
  logic              ack_on, rnw, mack;
  logic              scl_r, scl_f, start_c, stop_c;

  assign scl_r    = scl & ~scl_prev;
  assign scl_f    = ~scl & scl_prev;
  assign start_c  = scl & scl_prev & sda_prev & ~sda;
  assign stop_c   = scl & scl_prev & ~sda_prev & sda;
  assign byte_in  = {sh[BYTE_W-2:0], sda};
  assign reg_addr = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= TW_IDLE; cnt <= '0; sh <= '0; txb <= '0; txs <= '0; ptr <= '0;
      ack_on <= 1'b0; rnw <= 1'b0; mack <= 1'b0; sda_oe <= 1'b0;
      reg_wdata <= '0; reg_wr <= 1'b0; reg_rd <= 1'b0;
    end else begin
      reg_wr <= 1'b0;
      reg_rd <= 1'b0;
      if (reg_wr) ptr <= ptr + 1'b1;
      if (reg_rd) begin
        txb <= reg_rdata;
        ptr <= ptr + 1'b1;
      end
      if (!en) begin
        st <= TW_IDLE; sda_oe <= 1'b0; ack_on <= 1'b0;
      end else if (start_c) begin
        st <= TW_DEVADR; cnt <= '0; sda_oe <= 1'b0; ack_on <= 1'b0;
      end else if (stop_c) begin
        st <= TW_IDLE; sda_oe <= 1'b0; ack_on <= 1'b0;
      end else begin
        case (st)
          TW_DEVADR, TW_REGADR, TW_WRBYTE: begin
            if (scl_r) begin
              sh  <= byte_in;
              cnt <= cnt + 1'b1;
              if (cnt == LAST_BIT) begin
                cnt <= '0;
                if (st == TW_DEVADR) begin
                  if (byte_in[BYTE_W-1:1] == dev_addr) begin
                    rnw <= byte_in[0];
                    st  <= TW_DEVACK;
                  end else begin
                    st  <= TW_IDLE;
                  end
                end else if (st == TW_REGADR) begin
                  ptr <= byte_in;
                  st  <= TW_REGACK;
                end else begin
                  reg_wdata <= byte_in;
                  reg_wr    <= 1'b1;
                  st        <= TW_WRACK;
                end
              end
            end
          end
          TW_DEVACK, TW_REGACK, TW_WRACK: begin
            if (scl_f) begin
              if (!ack_on) begin
                sda_oe <= 1'b1;
                ack_on <= 1'b1;
                if (st == TW_DEVACK && rnw) reg_rd <= 1'b1;
              end else begin
                ack_on <= 1'b0;
                cnt    <= '0;
                if (st == TW_DEVACK && rnw) begin
                  st     <= TW_RDBYTE;
                  sda_oe <= ~txb[BYTE_W-1];
                  txs    <= {txb[BYTE_W-2:0], 1'b0};
                end else begin
                  sda_oe <= 1'b0;
                  st     <= (st == TW_DEVACK) ? TW_REGADR : TW_WRBYTE;
                end
              end
            end
          end
          TW_RDBYTE: begin
            if (scl_r) begin
              cnt <= cnt + 1'b1;
            end else if (scl_f) begin
              if (cnt == ALL_BITS) begin
                sda_oe <= 1'b0;
                st     <= TW_RDACK;
              end else begin
                sda_oe <= ~txs[BYTE_W-1];
                txs    <= {txs[BYTE_W-2:0], 1'b0};
              end
            end
          end
          TW_RDACK: begin
            if (scl_r) begin
              mack <= ~sda;
              if (!sda) reg_rd <= 1'b1;
            end else if (scl_f) begin
              cnt <= '0;
              if (mack) begin
                st     <= TW_RDBYTE;
                sda_oe <= ~txb[BYTE_W-1];
                txs    <= {txb[BYTE_W-2:0], 1'b0};
              end else begin
                st <= TW_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dsr_spi_engine.sv
module dsr_spi_engine import dsr_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              sck_prev,
  input  logic              si,
  output logic              so,
  output logic              so_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_wr,
  output logic              reg_rd,
  input  logic [BYTE_W-1:0] reg_rdata
);
  localparam int IDX_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(ADDR_W);
  localparam logic [IDX_W-1:0] DAT_LAST = IDX_W'(BYTE_W - 1);

  logic              hdr, rnw;
  logic [CNT_W-1:0]  hcnt;
  logic [IDX_W-1:0]  dcnt;
  logic [BYTE_W-1:0] sh, txb, byte_in;
  logic [ADDR_W-1:0] ptr;
  logic              sck_r, sck_f;

  assign sck_r    = sck & ~sck_prev;
  assign sck_f    = ~sck & sck_prev;
  assign byte_in  = {sh[BYTE_W-2:0], si};
  assign reg_addr = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr <= 1'b1; rnw <= 1'b0; hcnt <= '0; dcnt <= '0; sh <= '0; txb <= '0;
      ptr <= '0; so <= 1'b0; so_oe <= 1'b0;
      reg_wdata <= '0; reg_wr <= 1'b0; reg_rd <= 1'b0;
    end else begin
      reg_wr <= 1'b0;
      reg_rd <= 1'b0;
      if (reg_wr) ptr <= ptr + 1'b1;
      if (reg_rd) begin
        txb <= reg_rdata;
        ptr <= ptr + 1'b1;
      end
      if (!en || cs_n) begin
        hdr <= 1'b1; hcnt <= '0; dcnt <= '0; so_oe <= 1'b0;
      end else if (sck_r) begin
        if (hdr) begin
          hcnt <= hcnt + 1'b1;
          if (hcnt == '0) rnw <= si;
          else            sh  <= byte_in;
          if (hcnt == HDR_LAST) begin
            ptr  <= byte_in;
            hdr  <= 1'b0;
            dcnt <= '0;
            if (rnw) reg_rd <= 1'b1;
          end
        end else begin
          sh   <= byte_in;
          dcnt <= dcnt + 1'b1;
          if (dcnt == DAT_LAST) begin
            if (rnw) begin
              reg_rd <= 1'b1;
            end else begin
              reg_wdata <= byte_in;
              reg_wr    <= 1'b1;
            end
          end
        end
      end else if (sck_f && !hdr && rnw) begin
        so_oe <= 1'b1;
        so    <= txb[~dcnt];
      end
    end
  end
endmodule

// File: rtl/dual_serial_regslave.sv
module dual_serial_regslave import dsr_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk_i,
  input  logic              ser_dat_i,
  output logic              ser_dat_oe_o,
  input  logic              cs_n_i,
  input  logic              strap0_i,
  input  logic              strap1_i,
  output logic              so_o,
  output logic              so_oe_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic              reg_wr_o,
  output logic              reg_rd_o,
  input  logic [BYTE_W-1:0] reg_rdata_i
);
  localparam int PINS = 3;

  logic [PINS-1:0] pin_s, pin_p;
  logic            scl_s, dat_s, cs_s;
  logic            spi_mode, i2c_oe;
  logic [6:0]      dev_addr;

  logic [ADDR_W-1:0] tw_addr, sp_addr;
  logic [BYTE_W-1:0] tw_wdata, sp_wdata;
  logic              tw_wr, tw_rd, sp_wr, sp_rd;

  dsr_sync #(.W(PINS), .INIT('1)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({cs_n_i, ser_dat_i, ser_clk_i}),
    .q(pin_s), .q_prev(pin_p)
  );

  assign scl_s = pin_s[0];
  assign dat_s = pin_s[1];
  assign cs_s  = pin_s[2];

  dsr_mode_latch u_mode (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_s), .cs_n_prev(pin_p[2]), .spi_mode(spi_mode)
  );

  assign dev_addr = DEV_BASE + {5'd0, strap1_i, strap0_i};

  dsr_tw_engine u_tw (
    .clk(clk), .rst_n(rst_n), .en(~spi_mode),
    .scl(scl_s), .scl_prev(pin_p[0]), .sda(dat_s), .sda_prev(pin_p[1]),
    .dev_addr(dev_addr), .sda_oe(i2c_oe),
    .reg_addr(tw_addr), .reg_wdata(tw_wdata), .reg_wr(tw_wr), .reg_rd(tw_rd),
    .reg_rdata(reg_rdata_i)
  );

  dsr_spi_engine u_spi (
    .clk(clk), .rst_n(rst_n), .en(spi_mode), .cs_n(cs_s),
    .sck(scl_s), .sck_prev(pin_p[0]), .si(dat_s),
    .so(so_o), .so_oe(so_oe_o),
    .reg_addr(sp_addr), .reg_wdata(sp_wdata), .reg_wr(sp_wr), .reg_rd(sp_rd),
    .reg_rdata(reg_rdata_i)
  );

  assign ser_dat_oe_o = i2c_oe;
  assign reg_addr_o   = spi_mode ? sp_addr  : tw_addr;
  assign reg_wdata_o  = spi_mode ? sp_wdata : tw_wdata;
  assign reg_wr_o     = spi_mode ? sp_wr    : tw_wr;
  assign reg_rd_o     = spi_mode ? sp_rd    : tw_rd;
endmodule

// File: rtl/dsr_checker.sv
module dsr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       spi_mode,
  input logic       cs_s,
  input logic       scl_s,
  input logic       i2c_oe,
  input logic       so_oe,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic [7:0] reg_addr
);
  assert_mode_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    spi_mode |=> spi_mode);

  assert_so_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !so_oe);

  assert_tw_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
    spi_mode |=> !i2c_oe);

  assert_strobe_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));

  assert_sda_moves_low_R10: assert property (@(posedge clk) disable iff (!rst_n || spi_mode)
    !$stable(i2c_oe) |-> !scl_s);

  assert_index_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (reg_addr == $past(reg_addr) + 8'd1));
endmodule

bind dual_serial_regslave dsr_checker u_dsr_chk (
  .clk(clk), .rst_n(rst_n), .spi_mode(spi_mode), .cs_s(cs_s), .scl_s(scl_s),
  .i2c_oe(i2c_oe), .so_oe(so_oe_o), .reg_wr(reg_wr_o), .reg_rd(reg_rd_o),
  .reg_addr(reg_addr_o)
);

// File: tb/dual_serial_regslave_bench.sv
module dual_serial_regslave_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_clk = 1'b1, pin_dat = 1'b1, cs_n = 1'b1, strap0 = 1'b0, strap1 = 1'b0;
  logic ser_dat, dat_oe, so, so_oe, reg_wr, reg_rd;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic [7:0] bank [256];
  int compared = 0, mismatched = 0;

  always #2 clk = ~clk;

  assign ser_dat   = pin_dat & ~dat_oe;
  assign reg_rdata = bank[reg_addr];

  always @(posedge clk) if (reg_wr) bank[reg_addr] <= reg_wdata;

  dual_serial_regslave u_dual_serial_regslave (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(pin_clk), .ser_dat_i(ser_dat),
    .ser_dat_oe_o(dat_oe), .cs_n_i(cs_n), .strap0_i(strap0), .strap1_i(strap1),
    .so_o(so), .so_oe_o(so_oe), .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata),
    .reg_wr_o(reg_wr), .reg_rd_o(reg_rd), .reg_rdata_i(reg_rdata)
  );

  // {strap1, strap0, 7-bit address sent, ack expected}
  localparam logic [9:0] ADDR_TAB [8] = '{
    {2'b00, 7'h16, 1'b1}, {2'b00, 7'h17, 1'b0},
    {2'b01, 7'h17, 1'b1}, {2'b01, 7'h16, 1'b0},
    {2'b10, 7'h18, 1'b1}, {2'b10, 7'h19, 1'b0},
    {2'b11, 7'h19, 1'b1}, {2'b11, 7'h18, 1'b0}
  };

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tw_start();
    pin_dat = 1'b1; wait_n(4);
    pin_clk = 1'b1; wait_n(8);
    pin_dat = 1'b0; wait_n(8);
    pin_clk = 1'b0; wait_n(4);
  endtask

  task automatic tw_stop();
    pin_dat = 1'b0; wait_n(4);
    pin_clk = 1'b1; wait_n(8);
    pin_dat = 1'b1; wait_n(8);
  endtask

  task automatic tw_bit(input logic b, output logic r);
    wait_n(2);
    pin_dat = b; wait_n(8);
    pin_clk = 1'b1; wait_n(4);
    r = ser_dat; wait_n(4);
    pin_clk = 1'b0;
  endtask

  task automatic tw_wr(input logic [7:0] v, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) tw_bit(v[i], r);
    tw_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic tw_rd(input logic ack, output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      tw_bit(1'b1, r);
      v[i] = r;
    end
    tw_bit(~ack, r);
  endtask

  task automatic spi_xfer(input logic mode3, input logic rnw, input logic [7:0] adr,
                          input int n, input logic [7:0] din [4],
                          output logic [7:0] dout [4], output logic hdr_oe);
    logic [8:0] hdr;
    hdr = {rnw, adr};
    hdr_oe = 1'b0;
    pin_clk = mode3; wait_n(8);
    cs_n = 1'b0; wait_n(8);
    for (int k = 0; k < 9 + 8 * n; k++) begin
      if (mode3) pin_clk = 1'b0;
      if (k < 9) pin_dat = hdr[8 - k];
      else       pin_dat = din[(k - 9) / 8][7 - ((k - 9) % 8)];
      wait_n(8);
      pin_clk = 1'b1; wait_n(4);
      if (k < 9) hdr_oe = hdr_oe | so_oe;
      else       dout[(k - 9) / 8][7 - ((k - 9) % 8)] = so;
      wait_n(4);
      if (!mode3) pin_clk = 1'b0;
    end
    wait_n(8);
    cs_n = 1'b1; wait_n(8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL R1 watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] v, old;
    logic [7:0] din [4];
    logic [7:0] dout [4];
    logic hoe;
    for (int i = 0; i < 256; i++) bank[i] = 8'(i) ^ 8'h5A;
    for (int i = 0; i < 4; i++) begin din[i] = '0; dout[i] = '0; end
    wait_n(5);
    rst_n = 1'b1;
    wait_n(5);

    // R1 / R10: reset state of every output that can act
    check("R10 reset sda_oe", dat_oe, 0);
    check("R8 reset so_oe", so_oe, 0);
    check("R10 reset wr strobe", reg_wr, 0);
    check("R10 reset rd strobe", reg_rd, 0);

    // R2 / R3: strap-selected address table
    for (int i = 0; i < 8; i++) begin
      logic [1:0] st;
      logic [6:0] a7;
      logic ea;
      {st, a7, ea} = ADDR_TAB[i];
      {strap1, strap0} = st;
      old = bank[8'h40 + i];
      tw_start();
      tw_wr({a7, 1'b0}, ack);
      check(ea ? "R2 address ack" : "R3 mismatch nack", ack, ea);
      tw_wr(8'(8'h40 + i), ack);
      tw_wr(8'(8'hA0 + i), ack);
      tw_stop();
      wait_n(4);
      check(ea ? "R2 write landed" : "R3 no write", bank[8'h40 + i], ea ? 8'hA0 + i : old);
    end

    // R4: burst write at 0x10
    {strap1, strap0} = 2'b00;
    tw_start();
    tw_wr(8'h2C, ack); check("R4 dev ack", ack, 1);
    tw_wr(8'h10, ack); check("R4 index ack", ack, 1);
    tw_wr(8'h11, ack); check("R4 data0 ack", ack, 1);
    tw_wr(8'h22, ack); check("R4 data1 ack", ack, 1);
    tw_wr(8'h33, ack); check("R4 data2 ack", ack, 1);
    tw_stop();
    wait_n(4);
    check("R4 bank 0x10", bank[8'h10], 8'h11);
    check("R4 bank 0x12", bank[8'h12], 8'h33);
    check("R10 released after stop", dat_oe, 0);

    // R5: read back via repeated start
    tw_start();
    tw_wr(8'h2C, ack);
    tw_wr(8'h10, ack);
    tw_start();
    tw_wr(8'h2D, ack); check("R5 read ack", ack, 1);
    tw_rd(1'b1, v); check("R5 byte0", v, 8'h11);
    tw_rd(1'b1, v); check("R5 byte1", v, 8'h22);
    tw_rd(1'b0, v); check("R5 byte2", v, 8'h33);
    wait_n(8);
    check("R5 released after nack", dat_oe, 0);
    tw_stop();

    // R9: two-wire wrap
    tw_start();
    tw_wr(8'h2C, ack);
    tw_wr(8'hFF, ack);
    tw_wr(8'h5E, ack);
    tw_wr(8'h6F, ack);
    tw_stop();
    wait_n(4);
    check("R9 tw 0xFF", bank[8'hFF], 8'h5E);
    check("R9 tw wrap 0x00", bank[8'h00], 8'h6F);

    // R6 / R8: first chip-select fall, SPI mode 0 write
    din[0] = 8'hC3; din[1] = 8'h3C; din[2] = 8'h96;
    spi_xfer(1'b0, 1'b0, 8'h20, 3, din, dout, hoe);
    check("R8 header oe write", hoe, 0);
    check("R6 bank 0x20", bank[8'h20], 8'hC3);
    check("R6 bank 0x21", bank[8'h21], 8'h3C);
    check("R6 bank 0x22", bank[8'h22], 8'h96);

    // R7 / R8: SPI mode 0 read
    spi_xfer(1'b0, 1'b1, 8'h20, 3, din, dout, hoe);
    check("R8 header oe read", hoe, 0);
    check("R8 oe after cs high", so_oe, 0);
    check("R7 m0 byte0", dout[0], 8'hC3);
    check("R7 m0 byte1", dout[1], 8'h3C);
    check("R7 m0 byte2", dout[2], 8'h96);

    // R7 / R9: SPI mode 3 read across the wrap
    spi_xfer(1'b1, 1'b1, 8'hFE, 3, din, dout, hoe);
    check("R7 m3 byte0", dout[0], 8'hFE ^ 8'h5A);
    check("R9 spi 0xFF", dout[1], 8'h5E);
    check("R9 spi wrap 0x00", dout[2], 8'h6F);

    // R11: two-wire traffic ignored in SPI mode
    pin_clk = 1'b1; pin_dat = 1'b1; wait_n(8);
    old = bank[8'h30];
    tw_start();
    tw_wr(8'h2C, ack); check("R11 no ack in spi mode", ack, 0);
    tw_wr(8'h30, ack);
    tw_wr(8'h77, ack);
    tw_stop();
    wait_n(4);
    check("R11 no write in spi mode", bank[8'h30], old);

    // R1: still in SPI mode afterwards
    spi_xfer(1'b0, 1'b1, 8'h10, 1, din, dout, hoe);
    check("R1 spi mode kept", dout[0], 8'h11);

    // R1: reset restores the two-wire slave
    pin_clk = 1'b1; pin_dat = 1'b1;
    rst_n = 1'b0; wait_n(4);
    rst_n = 1'b1; wait_n(8);
    tw_start();
    tw_wr(8'h2C, ack); check("R1 ack after reset", ack, 1);
    tw_wr(8'h50, ack);
    tw_wr(8'h99, ack);
    tw_stop();
    wait_n(4);
    check("R1 write after reset", bank[8'h50], 8'h99);

    summary();
    $finish;
  end
endmodule